// File: doc/BRIEF.md
# Vector Register Allocation Word Expander

This block takes one packed allocation word and turns it into a width code and a type code for each of the 32 vector data registers. The word holds one 5-bit field per supported element type. A field of zero allocates nothing to that type. A non-zero field gives the number of the topmost register of that type, so each type gets a contiguous run of registers. The run starts one register above the previous non-zero field, or at register 0 for the lowest one.

On a request the word is checked for legality. A legal word produces, one cycle later, a single-cycle write strobe together with the full set of per-register codes. It also produces a strobe that clears the predicate register count, and it returns the supplied maximum vector length. An illegal word produces a single-cycle illegal strobe instead and changes nothing. An all-zero word is legal and leaves the unit unconfigured. While unconfigured, any other vector operation is flagged illegal.

The base layout has six fields. A parameter selects a wider 64-bit word with two more fields. Another parameter marks which types the implementation supports.

Top module: `vcfg_alloc_expander`

## Requirements
- R1: Fields sit at bits [5i+4:5i] for field index i, in the order X8, X16, X32, F16, F32, F64, X64, F128 from i=0 upward. Type codes are X8=1000, X16=1001, X32=1010, F16=0001, F32=0010, F64=0011, X64=1011, F128=0100. Width codes are 1000 for 8 bits, 1001 for 16, 1010 for 32, 1011 for 64 and 1100 for 128. Register r's codes appear at bits [4r+3:4r] of width_o and type_o.
- R2: A zero field allocates no registers. A non-zero field of value v gives its type to every register from one above the next lower non-zero field (or from register 0) up to register v.
- R3: Registers above the highest non-zero field get width 0000 and type 0000.
- R4: A request whose non-zero fields are not strictly increasing from low index to high index raises illegal_o and leaves all outputs except the strobes unchanged.
- R5: A request with any set bit above the top field (bits 31:30 in the base layout, bits 63:40 in the wide layout) raises illegal_o and changes nothing.
- R6: A request with a non-zero field for a type whose TYPE_EN bit is clear raises illegal_o and changes nothing.
- R7: A legal request pulses cfg_we_o and npred_clr_o for exactly one cycle, on the cycle after req_i. The new codes and mvl_o (equal to mvl_i at the request) appear on that same cycle. Without a request, neither strobe is raised.
- R8: An all-zero word is legal. It disables every register, sets unconfig_o to 1 and returns mvl_o = 0.
- R9: op_illegal_o is 1 exactly when op_i is 1 while unconfig_o is 1.
- R10: After reset all codes are 0000, unconfig_o is 1 and no strobe is active.
- R11: With WIDE=1 the word is 64 bits wide. The X64 field occupies bits 34:30 and the F128 field occupies bits 39:35.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Allocation word write request |
| word_i | input | WORD_W | Packed allocation word |
| mvl_i | input | MVL_W | Maximum vector length for the requested configuration |
| op_i | input | 1 | A non-configuration vector operation is issued |
| cfg_we_o | output | 1 | One-cycle strobe: new configuration accepted |
| npred_clr_o | output | 1 | One-cycle strobe: clear the predicate register count |
| illegal_o | output | 1 | One-cycle strobe: request rejected |
| unconfig_o | output | 1 | Unit holds no enabled registers |
| op_illegal_o | output | 1 | Issued operation is illegal because the unit is unconfigured |
| mvl_o | output | MVL_W | Returned maximum vector length (0 when unconfigured) |
| width_o | output | 4*NREG | Per-register width codes |
| type_o | output | 4*NREG | Per-register type codes |

## Verification
The hardest case to reach is a rejected word that follows a legal configuration. The check must show that the stored codes survive untouched, and that can only be seen if something distinctive was loaded first. Each rejection test therefore runs after a mixed configuration with four types. Registers whose codes differ by type are then read back. A second instance with the wide layout and one type disabled reaches the unsupported-type rejection and the upper field positions.

// File: rtl/vcfg_pkg.sv
package vcfg_pkg;
  localparam int FW = 5;
  localparam int CW = 4;
  localparam int MAX_FLD = 8;

  function automatic logic [CW-1:0] type_code(input int idx);
    case (idx)
      0: return 4'b1000;
      1: return 4'b1001;
      2: return 4'b1010;
      3: return 4'b0001;
      4: return 4'b0010;
      5: return 4'b0011;
      6: return 4'b1011;
      7: return 4'b0100;
      default: return 4'b0000;
    endcase
  endfunction

  function automatic logic [CW-1:0] width_code(input int idx);
    case (idx)
      0: return 4'b1000;
      1, 3: return 4'b1001;
      2, 4: return 4'b1010;
      5, 6: return 4'b1011;
      7: return 4'b1100;
      default: return 4'b0000;
    endcase
  endfunction
endpackage

// File: rtl/vcfg_word_check.sv
module vcfg_word_check
  import vcfg_pkg::*;
#(
  parameter int NFLD = 6,
  parameter int WORD_W = 32,
  parameter logic [MAX_FLD-1:0] TYPE_EN = '1
) (
  input  logic [WORD_W-1:0] word_i,
  output logic              legal_o,
  output logic              zero_o
);
  localparam int USED_W = NFLD * FW;

  logic          rsvd_bad;
  logic          order_bad;
  logic          type_bad;
  logic [FW-1:0] prev;
  logic [FW-1:0] fld;

  assign rsvd_bad = |word_i[WORD_W-1:USED_W];
  assign zero_o   = (word_i == '0);

  always_comb begin
    order_bad = 1'b0;
    type_bad  = 1'b0;
    prev      = '0;
    for (int i = 0; i < NFLD; i++) begin
      fld = word_i[i*FW +: FW];
      if (fld != '0) begin
        if (fld <= prev) order_bad = 1'b1;
        if (!TYPE_EN[i]) type_bad = 1'b1;
        prev = fld;
      end
    end
  end

  assign legal_o = !(rsvd_bad || order_bad || type_bad);
endmodule

// File: rtl/vcfg_reg_map.sv
module vcfg_reg_map
  import vcfg_pkg::*;
#(
  parameter int NFLD = 6,
  parameter int NREG = 32
) (
  input  logic [NFLD*FW-1:0] fields_i,
  output logic [NREG*CW-1:0] width_o,
  output logic [NREG*CW-1:0] type_o
);
  for (genvar r = 0; r < NREG; r++) begin : g_reg
    logic [CW-1:0] w_c;
    logic [CW-1:0] t_c;
    logic [FW-1:0] f;
    always_comb begin
      w_c = '0;
      t_c = '0;
      // lowest field whose top covers r owns it (fields are increasing)
      for (int i = NFLD - 1; i >= 0; i--) begin
        f = fields_i[i*FW +: FW];
        if (f != '0 && f >= FW'(r)) begin
          w_c = width_code(i);
          t_c = type_code(i);
        end
      end
    end
    assign width_o[r*CW +: CW] = w_c;
    assign type_o[r*CW +: CW]  = t_c;
  end
endmodule

// File: rtl/vcfg_alloc_expander.sv
module vcfg_alloc_expander
  import vcfg_pkg::*;
#(
  parameter bit WIDE = 1'b0,
  parameter int NREG = 32,
  parameter int MVL_W = 8,
  parameter logic [MAX_FLD-1:0] TYPE_EN = '1,
  localparam int NFLD = WIDE ? 8 : 6,
  localparam int WORD_W = WIDE ? 64 : 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [MVL_W-1:0]  mvl_i,
  input  logic              op_i,
  output logic              cfg_we_o,
  output logic              npred_clr_o,
  output logic              illegal_o,
  output logic              unconfig_o,
  output logic              op_illegal_o,
  output logic [MVL_W-1:0]  mvl_o,
  output logic [NREG*CW-1:0] width_o,
  output logic [NREG*CW-1:0] type_o
);
  logic               legal;
  logic               is_zero;
  logic [NREG*CW-1:0] width_d;
  logic [NREG*CW-1:0] type_d;
  logic               cfg_we_q;
  logic               illegal_q;
  logic               unconfig_q;
  logic [MVL_W-1:0]   mvl_q;
  logic [NREG*CW-1:0] width_q;
  logic [NREG*CW-1:0] type_q;

  vcfg_word_check #(.NFLD(NFLD), .WORD_W(WORD_W), .TYPE_EN(TYPE_EN)) u_check (
    .word_i (word_i),
    .legal_o(legal),
    .zero_o (is_zero)
  );

  vcfg_reg_map #(.NFLD(NFLD), .NREG(NREG)) u_map (
    .fields_i(word_i[NFLD*FW-1:0]),
    .width_o (width_d),
    .type_o  (type_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_we_q   <= 1'b0;
      illegal_q  <= 1'b0;
      unconfig_q <= 1'b1;
      mvl_q      <= '0;
      width_q    <= '0;
      type_q     <= '0;
    end else begin
      cfg_we_q  <= req_i && legal;
      illegal_q <= req_i && !legal;
      if (req_i && legal) begin
        width_q    <= width_d;
        type_q     <= type_d;
        unconfig_q <= is_zero;
        mvl_q      <= is_zero ? '0 : mvl_i;
      end
    end
  end

  assign cfg_we_o     = cfg_we_q;
  assign npred_clr_o  = cfg_we_q;
  assign illegal_o    = illegal_q;
  assign unconfig_o   = unconfig_q;
  assign op_illegal_o = op_i && unconfig_q;
  assign mvl_o        = mvl_q;
  assign width_o      = width_q;
  assign type_o       = type_q;
endmodule

// File: rtl/vcfg_alloc_expander_chk.sv
module vcfg_alloc_expander_chk #(
  parameter int NREG = 32,
  parameter int MVL_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              cfg_we_o,
  input logic              npred_clr_o,
  input logic              illegal_o,
  input logic              unconfig_o,
  input logic              op_illegal_o,
  input logic [MVL_W-1:0]  mvl_o,
  input logic [NREG*4-1:0] width_o,
  input logic [NREG*4-1:0] type_o
);
  a_r7_req_answered: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> (cfg_we_o ^ illegal_o));

  a_r7_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> (!cfg_we_o && !illegal_o && !npred_clr_o));

  a_r4_illegal_keeps_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> ($stable(width_o) && $stable(type_o) && $stable(unconfig_o) && $stable(mvl_o)));

  a_r8_unconfig_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unconfig_o |-> (width_o == '0 && type_o == '0));

  a_r8_unconfig_mvl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_o && unconfig_o) |-> (mvl_o == '0));

  a_r9_op_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_illegal_o |-> unconfig_o);

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    a_r2_pair_enabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (width_o[r*4 +: 4] == 4'b0000) == (type_o[r*4 +: 4] == 4'b0000));
    if (r < NREG - 1) begin : g_top
      a_r3_disabled_on_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (width_o[r*4 +: 4] == 4'b0000) |-> (width_o[(r+1)*4 +: 4] == 4'b0000));
    end
  end
endmodule

bind vcfg_alloc_expander vcfg_alloc_expander_chk #(.NREG(NREG), .MVL_W(MVL_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .cfg_we_o    (cfg_we_o),
  .npred_clr_o (npred_clr_o),
  .illegal_o   (illegal_o),
  .unconfig_o  (unconfig_o),
  .op_illegal_o(op_illegal_o),
  .mvl_o       (mvl_o),
  .width_o     (width_o),
  .type_o      (type_o)
);

// File: tb/vcfg_alloc_expander_test.sv
`timescale 1ns/1ps
module vcfg_alloc_expander_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, req_w = 1'b0, op = 1'b0;
  logic [31:0] word = '0;
  logic [63:0] word_w = '0;
  logic [7:0]  mvl = '0;
  logic        we, clr, ill, unc, opill;
  logic [7:0]  mvl_out;
  logic [127:0] wid, typ;
  logic        we_w, clr_w, ill_w, unc_w, opill_w;
  logic [7:0]  mvl_out_w;
  logic [127:0] wid_w, typ_w;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  vcfg_alloc_expander uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .word_i(word), .mvl_i(mvl), .op_i(op),
    .cfg_we_o(we), .npred_clr_o(clr), .illegal_o(ill), .unconfig_o(unc),
    .op_illegal_o(opill), .mvl_o(mvl_out), .width_o(wid), .type_o(typ));

  vcfg_alloc_expander #(.WIDE(1'b1), .TYPE_EN(8'h7F)) uut_w (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req_w), .word_i(word_w), .mvl_i(mvl), .op_i(op),
    .cfg_we_o(we_w), .npred_clr_o(clr_w), .illegal_o(ill_w), .unconfig_o(unc_w),
    .op_illegal_o(opill_w), .mvl_o(mvl_out_w), .width_o(wid_w), .type_o(typ_w));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic chk_reg(input string tag, input int r, input logic [3:0] w, input logic [3:0] t);
    chk({tag, $sformatf(" width v%0d", r)}, 32'(wid[4*r +: 4]), 32'(w));
    chk({tag, $sformatf(" type v%0d", r)}, 32'(typ[4*r +: 4]), 32'(t));
  endtask

  task automatic chk_reg_w(input string tag, input int r, input logic [3:0] w, input logic [3:0] t);
    chk({tag, $sformatf(" width v%0d", r)}, 32'(wid_w[4*r +: 4]), 32'(w));
    chk({tag, $sformatf(" type v%0d", r)}, 32'(typ_w[4*r +: 4]), 32'(t));
  endtask

  // request at negedge; registered outputs visible one negedge later
  task automatic apply(input logic [31:0] w, input logic [7:0] m);
    @(negedge clk); word = w; mvl = m; req = 1'b1;
    @(negedge clk); req = 1'b0;
  endtask

  task automatic apply_w(input logic [63:0] w, input logic [7:0] m);
    @(negedge clk); word_w = w; mvl = m; req_w = 1'b1;
    @(negedge clk); req_w = 1'b0;
  endtask

  task automatic t_reset;
    chk("R10 width", wid[31:0], 32'h0);
    chk("R10 type", typ[127:96], 32'h0);
    chk("R10 unconfig", 32'(unc), 1);
    chk("R10 strobes", {30'h0, we, ill}, 0);
  endtask

  task automatic t_example;
    apply((32'd1 << 10) | (32'd12 << 20) | (32'd18 << 25), 8'd40);
    chk("R7 cfg_we", 32'(we), 1);
    chk("R7 npred_clr", 32'(clr), 1);
    chk("R7 illegal", 32'(ill), 0);
    chk("R7 mvl", 32'(mvl_out), 40);
    chk("R8 unconfig", 32'(unc), 0);
    chk_reg("R1 R2 X32", 0, 4'b1010, 4'b1010);
    chk_reg("R2 X32", 1, 4'b1010, 4'b1010);
    chk_reg("R2 F32", 2, 4'b1010, 4'b0010);
    chk_reg("R2 F32", 12, 4'b1010, 4'b0010);
    chk_reg("R2 F64", 13, 4'b1011, 4'b0011);
    chk_reg("R2 F64", 18, 4'b1011, 4'b0011);
    chk_reg("R3 top", 19, 4'b0000, 4'b0000);
    chk_reg("R3 top", 31, 4'b0000, 4'b0000);
    @(negedge clk);
    chk("R7 one-cycle strobe", {30'h0, we, clr}, 0);
  endtask

  task automatic t_all_x8;
    apply(32'd31, 8'd128);
    chk_reg("R2 X8 full", 0, 4'b1000, 4'b1000);
    chk_reg("R2 X8 full", 31, 4'b1000, 4'b1000);
    chk("R7 mvl", 32'(mvl_out), 128);
  endtask

  task automatic t_mixed;
    apply(32'd1 | (32'd3 << 5) | (32'd5 << 15) | (32'd9 << 20), 8'd20);
    chk_reg("R1 X8", 1, 4'b1000, 4'b1000);
    chk_reg("R1 X16", 2, 4'b1001, 4'b1001);
    chk_reg("R1 F16", 4, 4'b1001, 4'b0001);
    chk_reg("R1 F16", 5, 4'b1001, 4'b0001);
    chk_reg("R1 F32", 9, 4'b1010, 4'b0010);
    chk_reg("R3 above", 10, 4'b0000, 4'b0000);
  endtask

  task automatic t_order_bad;
    apply(32'd5 | (32'd3 << 5), 8'd9);
    chk("R4 illegal decreasing", 32'(ill), 1);
    chk("R4 no cfg_we", 32'(we), 0);
    chk_reg("R4 kept", 4, 4'b1001, 4'b0001);
    chk("R4 mvl kept", 32'(mvl_out), 20);
    apply(32'd4 | (32'd4 << 10), 8'd9);
    chk("R4 illegal equal", 32'(ill), 1);
    chk_reg("R4 kept", 0, 4'b1000, 4'b1000);
  endtask

  task automatic t_reserved;
    apply(32'd31 | (32'd1 << 31), 8'd9);
    chk("R5 illegal", 32'(ill), 1);
    chk_reg("R5 kept", 6, 4'b1010, 4'b0010);
    chk_reg("R5 kept", 20, 4'b0000, 4'b0000);
  endtask

  task automatic t_zero;
    @(negedge clk); op = 1'b1;
    #1 chk("R9 configured op", 32'(opill), 0);
    op = 1'b0;
    apply(32'd0, 8'd16);
    chk("R8 legal", 32'(we), 1);
    chk("R8 unconfig", 32'(unc), 1);
    chk("R8 mvl zero", 32'(mvl_out), 0);
    chk_reg("R8 disabled", 0, 4'b0000, 4'b0000);
    op = 1'b1;
    #1 chk("R9 unconfigured op", 32'(opill), 1);
    op = 1'b0;
  endtask

  task automatic t_wide;
    apply_w(64'd1 | (64'd20 << 30), 8'd50);
    chk("R11 legal", 32'(we_w), 1);
    chk_reg_w("R11 X8", 1, 4'b1000, 4'b1000);
    chk_reg_w("R11 X64", 2, 4'b1011, 4'b1011);
    chk_reg_w("R11 X64", 20, 4'b1011, 4'b1011);
    chk_reg_w("R3 wide top", 21, 4'b0000, 4'b0000);
    apply_w(64'd1 | (64'd20 << 30) | (64'd25 << 35), 8'd50);
    chk("R6 unsupported F128", 32'(ill_w), 1);
    chk_reg_w("R6 kept", 21, 4'b0000, 4'b0000);
    apply_w(64'd1 | (64'd1 << 40), 8'd50);
    chk("R5 wide reserved", 32'(ill_w), 1);
    chk_reg_w("R5 wide kept", 2, 4'b1011, 4'b1011);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_example;
    t_all_x8;
    t_mixed;
    t_order_bad;
    t_reserved;
    t_zero;
    t_wide;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule